// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product. It has no clock and no state: the product is a pure function of the two operand inputs and follows them within the same clock period in which they change. It is meant to be placed in a datapath where the surrounding registers set the timing budget.

The product is built by recursive halving. At the bottom sits a 2x2 cell made only of four AND gates and two half adders. Every wider stage splits each operand into a high and a low half and forms four half-width sub-products: low by low, high by low, low by high and high by high. Three ripple-carry adders then merge them. The low quarter of the result comes straight from the low-by-low sub-product. The cross terms and the upper half of low-by-low are summed to give the second quarter. The rest of that sum is added to high-by-high to give the upper half.

The width N is a parameter. It must be a power of two from 2 to 64, and the default is 16.

Top module: `vcm_mul`

## Requirements
- R1: For every pair of unsigned operands, the output equals op_a × op_b as an unsigned 2N-bit value.
- R2: N must be a power of two no smaller than 2 (default 16, tested up to 64); any other value stops elaboration with an error.
- R3: With N=2, the output bits follow the base cell exactly: bit0 = a0&b0; bit1 = (a0&b1)^(a1&b0); bit2 = (a1&b1)^c; bit3 = (a1&b1)&c, where c = a0&b1&a1&b0.
- R4: Output bits [N/2-1:0] equal the low N/2 bits of the product of the low halves of the two operands.
- R5: At every merge stage, neither the middle adder nor the top adder produces a carry out.
- R6: A zero on either operand gives a zero product. All-ones times all-ones gives 2^(2N) − 2^(N+1) + 1.
- R7: When one operand is 1, the product equals the other operand zero-extended to 2N bits.
- R8: The output has no register stage, so it reflects the current operands in the same clock period in which they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product op_a × op_b |

## Verification
Every result is due zero cycles after its stimulus, because there is no register between the operand pins and the product. The bench applies the operands just after a rising edge of its own clock. It samples the product at the following falling edge, half a period later, so the combinational path has settled and no check depends on the order of processes at an edge. Widths 2, 4 and 8 are swept over every operand pair. Widths 16, 32 and 64 get random pairs, and 64 also gets a table of corner vectors with their expected products.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

    // Sum and carry of a two-input adder stage.
    typedef struct packed {
        logic sum;
        logic carry;
    } vcm_sc_t;

    // True when n is a positive power of two.
    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

    // Largest operand width the recursion is sized for.
    localparam int VCM_MAX_W = 64;

endpackage

// File: rtl/vcm_ha.sv
module vcm_ha
    import vcm_pkg::*;
(
    input  logic    x,
    input  logic    y,
    output vcm_sc_t o
);
    assign o.sum   = x ^ y;
    assign o.carry = x & y;
endmodule

// File: rtl/vcm_cell2.sv
module vcm_cell2
    import vcm_pkg::*;
(
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic    t00, t01, t10, t11;
    vcm_sc_t ha_lo, ha_hi;

    // Four bit products.
    assign t00 = a[0] & b[0];
    assign t01 = a[0] & b[1];
    assign t10 = a[1] & b[0];
    assign t11 = a[1] & b[1];

    vcm_ha u_ha_lo (.x(t01), .y(t10),         .o(ha_lo));
    vcm_ha u_ha_hi (.x(t11), .y(ha_lo.carry), .o(ha_hi));

    assign p = {ha_hi.carry, ha_hi.sum, ha_lo.sum, t00};

    // R3: the cell's output is the true 2x2 product.
    always_comb begin
        if (!$isunknown({a, b, p}))
            assert_cell_product_R3: assert (p == 4'(a) * 4'(b));
    end

    // R3: the top carry rises only when both operands are 3.
    always_comb begin
        if (!$isunknown({a, b, p}))
            assert_cell_topcarry_R3: assert (!p[3] || (a == 2'b11 && b == 2'b11));
    end
endmodule

// File: rtl/vcm_rca.sv
module vcm_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic prop;
        assign prop       = a[i] ^ b[i];
        assign sum[i]     = prop ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (prop & chain[i]);
    end

    assign cout = chain[W];
endmodule

// File: rtl/vcm_node.sv
module vcm_node #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int H = W / 2;

    if (W == 2) begin : g_base
        vcm_cell2 u_cell (.a(a), .b(b), .p(p));
    end else begin : g_split
        logic [W-1:0] ll, hl, lh, hh;

        vcm_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
        vcm_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(hl));
        vcm_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(lh));
        vcm_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(hh));

        // Cross terms summed into W+1 bits.
        logic [W-1:0] s1;
        logic         c1;
        vcm_rca #(.W(W)) u_add_cross (
            .a(hl), .b(lh), .cin(1'b0), .sum(s1), .cout(c1)
        );

        // Cross sum plus upper half of low-by-low.
        logic [W:0] mid_a, mid_b, s2;
        logic       c2;
        assign mid_a = {c1, s1};
        assign mid_b = {{(H + 1){1'b0}}, ll[W-1:H]};
        vcm_rca #(.W(W + 1)) u_add_mid (
            .a(mid_a), .b(mid_b), .cin(1'b0), .sum(s2), .cout(c2)
        );

        // Upper part of the middle sum plus high-by-high.
        logic [W-1:0] top_b, s3;
        logic         c3;
        assign top_b = {{(H - 1){1'b0}}, s2[W:H]};
        vcm_rca #(.W(W)) u_add_top (
            .a(hh), .b(top_b), .cin(1'b0), .sum(s3), .cout(c3)
        );

        assign p = {s3, s2[H-1:0], ll[H-1:0]};

        // R5: the middle merge never carries out.
        always_comb begin
            if (!$isunknown({a, b, c2}))
                assert_no_overflow_mid_R5: assert (!c2);
        end

        // R5: the top merge never carries out.
        always_comb begin
            if (!$isunknown({a, b, c3}))
                assert_no_overflow_top_R5: assert (!c3);
        end
    end
endmodule

// File: rtl/vcm_mul.sv
module vcm_mul
    import vcm_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] prod
);
    localparam int PW = 2 * N;
    localparam int HW = N / 2;

    // R2: reject widths the recursion cannot build.
    if (N < 2 || N > VCM_MAX_W || !is_pow2(N)) begin : g_bad_width
        $error("vcm_mul: N must be a power of two between 2 and 64");
    end

    vcm_node #(.W(N)) u_root (.a(op_a), .b(op_b), .p(prod));

    // R1: full product check against an independent multiply.
    always_comb begin
        if (!$isunknown({op_a, op_b, prod}))
            assert_full_product_R1: assert (prod == PW'(op_a) * PW'(op_b));
    end

    // R4: low quarter comes from the low halves alone.
    always_comb begin
        if (!$isunknown({op_a, op_b, prod}))
            assert_low_quarter_R4: assert (
                prod[HW-1:0] == HW'(N'(op_a[HW-1:0]) * N'(op_b[HW-1:0])));
    end

    // R6: a zero operand forces a zero product.
    always_comb begin
        if (!$isunknown({op_a, op_b, prod}) && (op_a == '0 || op_b == '0))
            assert_zero_operand_R6: assert (prod == '0);
    end
endmodule

// File: tb/vcm_mul_tb_top.sv
module vcm_mul_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [7:0]   a8, b8;    logic [15:0]  p8;
    logic [3:0]   a4, b4;    logic [7:0]   p4;
    logic [1:0]   a2, b2;    logic [3:0]   p2;
    logic [15:0]  a16, b16;  logic [31:0]  p16;
    logic [31:0]  a32, b32;  logic [63:0]  p32;
    logic [63:0]  a64, b64;  logic [127:0] p64;

    vcm_mul #(.N(8))  dut_i   (.op_a(a8),  .op_b(b8),  .prod(p8));
    vcm_mul #(.N(4))  dut4_i  (.op_a(a4),  .op_b(b4),  .prod(p4));
    vcm_mul #(.N(2))  dut2_i  (.op_a(a2),  .op_b(b2),  .prod(p2));
    vcm_mul #(.N(16)) dut16_i (.op_a(a16), .op_b(b16), .prod(p16));
    vcm_mul #(.N(32)) dut32_i (.op_a(a32), .op_b(b32), .prod(p32));
    vcm_mul #(.N(64)) dut64_i (.op_a(a64), .op_b(b64), .prod(p64));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Corner table for N=64: {a, b, expected product}.
    localparam int NT = 8;
    localparam logic [63:0]  TA [NT] = '{
        64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
        64'h0, 64'h1_0000_0000};
    localparam logic [63:0]  TB [NT] = '{
        64'h0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1,
        64'h2, 64'h8000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000};
    localparam logic [127:0] TP [NT] = '{
        128'h0, 128'h1234_5678_9ABC_DEF0,
        128'hFFFF_FFFF_FFFF_FFFE_0000_0000_0000_0001,
        128'hFFFF_FFFF_FFFF_FFFF,
        128'h1_0000_0000_0000_0000,
        128'h4000_0000_0000_0000_0000_0000_0000_0000,
        128'h0, 128'h1_0000_0000_0000_0000};

    initial begin
        a8 = '0; b8 = '0; a4 = '0; b4 = '0; a2 = '0; b2 = '0;
        a16 = '0; b16 = '0; a32 = '0; b32 = '0; a64 = '0; b64 = '0;

        // Initial state: zero operands give zero at once (R6, R8).
        @(negedge clk);
        chk("R6 zero operands N=8", 128'(p8), 128'h0);
        chk("R8 same-period result N=64", p64, 128'h0);

        // Table walk for N=64 (R1, R6, R7).
        for (int t = 0; t < NT; t++) begin
            @(posedge clk);
            a64 = TA[t]; b64 = TB[t];
            @(negedge clk);
            chk("R1 table N=64", p64, TP[t]);
        end

        // Exhaustive sweep for N=8, 4 and 2 (R1, R3, R4).
        for (int i = 0; i < 65536; i++) begin
            @(posedge clk);
            a8 = 8'(i >> 8); b8 = 8'(i);
            a4 = 4'(i >> 4); b4 = 4'(i);
            a2 = 2'(i >> 2); b2 = 2'(i);
            @(negedge clk);
            chk("R1 exhaustive N=8", 128'(p8), 128'(16'(a8) * 16'(b8)));
            chk("R4 low quarter N=8", 128'(p8[3:0]), 128'(4'(a8[3:0] * b8[3:0])));
            if (i < 256)
                chk("R1 exhaustive N=4", 128'(p4), 128'(8'(a4) * 8'(b4)));
            if (i < 16) begin
                logic cc;
                cc = a2[0] & b2[1] & a2[1] & b2[0];
                chk("R3 base cell N=2", 128'(p2),
                    128'({(a2[1] & b2[1]) & cc, (a2[1] & b2[1]) ^ cc,
                          (a2[0] & b2[1]) ^ (a2[1] & b2[0]), a2[0] & b2[0]}));
            end
        end

        // Random vectors for N=16, 32, 64 (R1, R4).
        void'($urandom(32'd7));
        for (int r = 0; r < 2000; r++) begin
            @(posedge clk);
            a16 = 16'($urandom); b16 = 16'($urandom);
            a32 = $urandom;      b32 = $urandom;
            a64 = {$urandom, $urandom}; b64 = {$urandom, $urandom};
            @(negedge clk);
            chk("R1 random N=16", 128'(p16), 128'(32'(a16) * 32'(b16)));
            chk("R1 random N=32", 128'(p32), 128'(64'(a32) * 64'(b32)));
            chk("R1 random N=64", p64, 128'(a64) * 128'(b64));
            chk("R4 low quarter N=64", 128'(p64[31:0]), 128'(32'(a64[31:0] * b64[31:0])));
        end

        // Directed corners at 16 and 32 (R6, R7).
        @(posedge clk);
        a16 = '1; b16 = '1; a32 = 32'h1; b32 = 32'hDEAD_BEEF;
        @(negedge clk);
        chk("R6 all-ones N=16", 128'(p16), 128'h FFFE_0001);
        chk("R7 unit operand N=32", 128'(p32), 128'h DEAD_BEEF);
        @(posedge clk);
        a16 = 16'h0; b16 = 16'hFFFF; a32 = '1; b32 = '1;
        @(negedge clk);
        chk("R6 zero operand N=16", 128'(p16), 128'h0);
        chk("R6 all-ones N=32", 128'(p32), 128'h FFFF_FFFE_0000_0001);

        // R8: change operands, product follows within the same period.
        @(posedge clk);
        a8 = 8'd200; b8 = 8'd3;
        @(negedge clk);
        chk("R8 same-period result N=8", 128'(p8), 128'd600);
        // R2: default-width elaboration is covered by the legal widths above.

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule